// File: doc/BRIEF.md
# Daisy-Chain Enumeration Controller

This block runs once per request, normally right after power-up, to learn how many monitor devices are linked in a serial daisy chain behind the master device and to confirm that each one answers with the address that matches its place in the chain. It issues a fixed series of three broadcast register writes: a configuration write that also resets the devices, the same configuration without the reset, and a write that points the readback at the configuration register. It then asks for response frames one at a time. Each frame is screened for an all-zero word, a valid 8-bit CRC, and a device address that matches the frame's index.

An all-zero frame ends the scan, and the number of devices behind the master is stored in a count register. Any bad frame ends the scan with a sticky error flag, and the count keeps its last good value. Frame packing and serial pin timing are handled by a neighbouring block. That block receives one command at a time from this controller and pulses `xfer_done` when the transfer has finished. For a read, `rsp_word` carries the received 32-bit frame in the same cycle as `xfer_done`.

Top module: `chain_enumerator`

## Requirements
- R1: While reset is applied and until the first start, `busy`, `done`, `err`, `cmd_valid` and `dev_count` are all 0.
- R2: A start seen while idle produces three write commands, in this order. Each has `cmd_read`=0, `cmd_dev`=0 and `cmd_all`=1.
  - The first goes to register 0x0E with data 0x95 | (ACQ_CODE<<5). The bits are: reset in bit 7, must-be-one in bit 4, address lock in bit 2 and chain readback in bit 0.
  - The second goes to register 0x0E with the same data but bit 7 cleared.
  - The third goes to register 0x1C with data 0x38 (0x0E shifted left by two).
- R3: After the writes, read commands (`cmd_read`=1) follow one per completed transfer until the scan ends. A command stays asserted, with its fields unchanged, until `xfer_done`.
- R4: A zero word at frame index n≥1 ends the scan with `dev_count`=n−1 and `err`=0. `done` is high for exactly one cycle. The stored count then holds until a later scan succeeds.
- R5: A non-zero frame fails when its bits 9:2 differ from the remainder of bits 31:10, taken as a 22-bit polynomial, divided by x^8+x^5+x^3+x^2+x+1.
- R6: A non-zero frame fails unless its bits 31:27, read with bit 31 as the least significant, equal the frame index.
- R7: At most MAX_DEV+1 frames (indices 0 to 8 by default) are read. A non-zero frame at index MAX_DEV fails the scan.
- R8: A zero word at index 0 fails the scan.
- R9: A failed scan sets `err`, pulses `done` and leaves `dev_count` unchanged.
- R10: Starting a scan clears `err`. A start that arrives while a scan is in progress, including in its `done` cycle, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Enumeration request, accepted when idle |
| xfer_done | input | 1 | Pulse: the current command's transfer completed |
| rsp_word | input | 32 | Received frame, valid with `xfer_done` on reads |
| cmd_valid | output | 1 | A command is pending for the frame packer |
| cmd_read | output | 1 | 1 = fetch one response frame, 0 = register write |
| cmd_dev | output | 5 | Target device address of the write |
| cmd_reg | output | 6 | Target register of the write |
| cmd_all | output | 1 | Broadcast to every device in the chain |
| cmd_data | output | 8 | Write data |
| busy | output | 1 | A scan is in progress (including the done cycle) |
| done | output | 1 | One-cycle pulse when a scan finishes |
| err | output | 1 | Sticky failure flag of the last scan |
| dev_count | output | 4 | Devices found behind the master by the last good scan |

## Verification
Two things can land in the same cycle: the `done` pulse that closes a scan, and a fresh start request. The bench raises `start` in exactly the cycle in which it sees `done`. It then requires that no new command appears and that `busy` falls one cycle later. It also raises `start` while it is serving the second configuration write, and requires that exactly three writes reach the packer and that the scan finishes with the correct count.

// File: rtl/chain_enum_pkg.sv
package chain_enum_pkg;

   localparam int CRC_W    = 8;
   localparam int CRC_SPAN = 22;
   localparam logic [CRC_W:0] CRC_POLY = 9'h12F;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_CFG,
      ST_PTR,
      ST_READ,
      ST_FIN
   } enum_state_t;

   // remainder by long division, one bit per step
   function automatic logic [CRC_W-1:0] crc_divide(input logic [CRC_SPAN-1:0] x);
      logic [CRC_SPAN-1:0] r;
      r = x;
      for (int i = CRC_SPAN - 1; i >= CRC_W; i--) begin
         if (r[i]) r[i-:CRC_W+1] = r[i-:CRC_W+1] ^ CRC_POLY;
      end
      return r[CRC_W-1:0];
   endfunction

   // byte * x^8 mod P
   function automatic logic [CRC_W-1:0] crc_byte_step(input logic [CRC_W-1:0] v);
      logic [CRC_W-1:0] c;
      c = v;
      for (int i = 0; i < CRC_W; i++) begin
         if (c[CRC_W-1]) c = (c << 1) ^ CRC_POLY[CRC_W-1:0];
         else            c = c << 1;
      end
      return c;
   endfunction

   // same remainder, folded a byte at a time
   function automatic logic [CRC_W-1:0] crc_bytewise(input logic [CRC_SPAN-1:0] x);
      logic [CRC_W-1:0] c;
      c = crc_byte_step({2'b00, x[21:16]});
      c = crc_byte_step(c ^ x[15:8]);
      return c ^ x[7:0];
   endfunction

endpackage

// File: rtl/chain_frame_check.sv
module chain_frame_check
   import chain_enum_pkg::*;
#(
   parameter int FRAME_W   = 32,
   parameter int ADDR_W    = 5,
   parameter int IDX_W     = 4,
   parameter int CRC_STYLE = 1
) (
   input  logic [FRAME_W-1:0] word,
   input  logic [IDX_W-1:0]   idx,
   output logic               is_zero,
   output logic               crc_ok,
   output logic               pos_ok
);

   localparam int CRC_LSB  = 2;
   localparam int SPAN_LSB = CRC_LSB + CRC_W;
   localparam int ADDR_TOP = FRAME_W - 1;

   if (FRAME_W != SPAN_LSB + CRC_SPAN) begin : g_bad_frame
      $error("frame width must cover address, payload and CRC");
   end
   if (IDX_W > ADDR_W) begin : g_bad_idx
      $error("index wider than device address");
   end

   logic [ADDR_W-1:0]   addr_rev;
   logic [CRC_W-1:0]    crc_calc;
   logic [CRC_SPAN-1:0] span;

   assign span = word[FRAME_W-1:SPAN_LSB];

   for (genvar b = 0; b < ADDR_W; b++) begin : g_rev
      assign addr_rev[b] = word[ADDR_TOP-b];
   end

   if (CRC_STYLE == 0) begin : g_crc_div
      assign crc_calc = crc_divide(span);
   end else if (CRC_STYLE == 1) begin : g_crc_byte
      assign crc_calc = crc_bytewise(span);
   end else begin : g_crc_bad
      $error("CRC_STYLE must be 0 or 1");
      assign crc_calc = '0;
   end

   assign is_zero = (word == '0);
   assign crc_ok  = (crc_calc == word[SPAN_LSB-1:CRC_LSB]);
   assign pos_ok  = (addr_rev == ADDR_W'(idx));

endmodule

// File: rtl/chain_cmd_gen.sv
module chain_cmd_gen
   import chain_enum_pkg::*;
#(
   parameter int DEV_W      = 5,
   parameter int REG_W      = 6,
   parameter int DATA_W     = 8,
   parameter int ACQ_CODE   = 0,
   parameter int CTRL_REG   = 'h0E,
   parameter int RPTR_REG   = 'h1C
) (
   input  enum_state_t        state,
   output logic               cmd_valid,
   output logic               cmd_read,
   output logic [DEV_W-1:0]   cmd_dev,
   output logic [REG_W-1:0]   cmd_reg,
   output logic               cmd_all,
   output logic [DATA_W-1:0]  cmd_data
);

   localparam int BIT_RST  = 7;
   localparam int BIT_ACQ  = 5;
   localparam int BIT_ONE  = 4;
   localparam int BIT_LOCK = 2;
   localparam int BIT_RB   = 0;

   if (ACQ_CODE < 0 || ACQ_CODE > 3) begin : g_bad_acq
      $error("ACQ_CODE must fit two bits");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("register data is one byte");
   end
   if (CTRL_REG >= (1 << REG_W) || RPTR_REG >= (1 << REG_W)) begin : g_bad_reg
      $error("register index exceeds REG_W");
   end

   localparam logic [DATA_W-1:0] CFG_DATA =
      DATA_W'((1 << BIT_ONE) | (1 << BIT_LOCK) | (1 << BIT_RB) | (ACQ_CODE << BIT_ACQ));
   localparam logic [DATA_W-1:0] RST_DATA = CFG_DATA | DATA_W'(1 << BIT_RST);
   localparam logic [DATA_W-1:0] PTR_DATA = DATA_W'(CTRL_REG << 2);
   localparam logic [REG_W-1:0]  CTRL_IDX = REG_W'(CTRL_REG);
   localparam logic [REG_W-1:0]  RPTR_IDX = REG_W'(RPTR_REG);

   always_comb begin
      cmd_valid = 1'b0;
      cmd_read  = 1'b0;
      cmd_dev   = '0;
      cmd_reg   = '0;
      cmd_all   = 1'b0;
      cmd_data  = '0;
      case (state)
         ST_RST: begin
            cmd_valid = 1'b1;
            cmd_all   = 1'b1;
            cmd_reg   = CTRL_IDX;
            cmd_data  = RST_DATA;
         end
         ST_CFG: begin
            cmd_valid = 1'b1;
            cmd_all   = 1'b1;
            cmd_reg   = CTRL_IDX;
            cmd_data  = CFG_DATA;
         end
         ST_PTR: begin
            cmd_valid = 1'b1;
            cmd_all   = 1'b1;
            cmd_reg   = RPTR_IDX;
            cmd_data  = PTR_DATA;
         end
         ST_READ: begin
            cmd_valid = 1'b1;
            cmd_read  = 1'b1;
            cmd_dev   = '1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/chain_enum_fsm.sv
module chain_enum_fsm
   import chain_enum_pkg::*;
#(
   parameter int MAX_DEV = 8,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             xfer_done,
   input  logic             is_zero,
   input  logic             crc_ok,
   input  logic             pos_ok,
   output enum_state_t      state,
   output logic [IDX_W-1:0] idx,
   output logic             accept,
   output logic             settle_ok,
   output logic             settle_fail
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_DEV);

   enum_state_t nxt;
   logic        read_end;
   logic        frame_bad;

   always_comb begin
      accept      = (state == ST_IDLE) && start;
      read_end    = (state == ST_READ) && xfer_done;
      frame_bad   = !crc_ok || !pos_ok || (idx == LAST_IDX);
      settle_ok   = read_end && is_zero && (idx != '0);
      settle_fail = read_end && (is_zero ? (idx == '0) : frame_bad);
   end

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE: if (start)     nxt = ST_RST;
         ST_RST:  if (xfer_done) nxt = ST_CFG;
         ST_CFG:  if (xfer_done) nxt = ST_PTR;
         ST_PTR:  if (xfer_done) nxt = ST_READ;
         ST_READ: if (settle_ok || settle_fail) nxt = ST_FIN;
         ST_FIN:  nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         state <= nxt;
         if (accept)
            idx <= '0;
         else if (read_end && !is_zero && !frame_bad)
            idx <= idx + IDX_W'(1);
      end
   end

   AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIN) |=> (state == ST_IDLE));                    // R4
   AST_IDX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST_IDX);                                              // R7
   AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READ && !xfer_done) |=> (state == ST_READ));      // R3

endmodule

// File: rtl/chain_enumerator.sv
module chain_enumerator
   import chain_enum_pkg::*;
#(
   parameter int MAX_DEV   = 8,
   parameter int FRAME_W   = 32,
   parameter int DEV_W     = 5,
   parameter int REG_W     = 6,
   parameter int DATA_W    = 8,
   parameter int ACQ_CODE  = 0,
   parameter int CRC_STYLE = 1,
   localparam int IDX_W    = $clog2(MAX_DEV + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               xfer_done,
   input  logic [FRAME_W-1:0] rsp_word,
   output logic               cmd_valid,
   output logic               cmd_read,
   output logic [DEV_W-1:0]   cmd_dev,
   output logic [REG_W-1:0]   cmd_reg,
   output logic               cmd_all,
   output logic [DATA_W-1:0]  cmd_data,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic [IDX_W-1:0]   dev_count
);

   if (MAX_DEV < 1 || MAX_DEV >= (1 << DEV_W)) begin : g_bad_max
      $error("MAX_DEV must be 1 .. 2**DEV_W-1");
   end

   enum_state_t      state;
   logic [IDX_W-1:0] idx;
   logic             accept, settle_ok, settle_fail;
   logic             is_zero, crc_ok, pos_ok;

   chain_frame_check #(
      .FRAME_W   (FRAME_W),
      .ADDR_W    (DEV_W),
      .IDX_W     (IDX_W),
      .CRC_STYLE (CRC_STYLE)
   ) u_check (
      .word    (rsp_word),
      .idx     (idx),
      .is_zero (is_zero),
      .crc_ok  (crc_ok),
      .pos_ok  (pos_ok)
   );

   chain_enum_fsm #(
      .MAX_DEV (MAX_DEV),
      .IDX_W   (IDX_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .xfer_done   (xfer_done),
      .is_zero     (is_zero),
      .crc_ok      (crc_ok),
      .pos_ok      (pos_ok),
      .state       (state),
      .idx         (idx),
      .accept      (accept),
      .settle_ok   (settle_ok),
      .settle_fail (settle_fail)
   );

   chain_cmd_gen #(
      .DEV_W    (DEV_W),
      .REG_W    (REG_W),
      .DATA_W   (DATA_W),
      .ACQ_CODE (ACQ_CODE)
   ) u_cmd (
      .state     (state),
      .cmd_valid (cmd_valid),
      .cmd_read  (cmd_read),
      .cmd_dev   (cmd_dev),
      .cmd_reg   (cmd_reg),
      .cmd_all   (cmd_all),
      .cmd_data  (cmd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_count <= '0;
         err       <= 1'b0;
      end else begin
         if (settle_ok)
            dev_count <= idx - IDX_W'(1);
         if (accept)
            err <= 1'b0;
         else if (settle_fail)
            err <= 1'b1;
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_FIN);

   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> !err);                                    // R10
   AST_COUNT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && !err) |-> $stable(dev_count));                       // R9
   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !xfer_done) |=> (cmd_valid && $stable(cmd_reg) && $stable(cmd_data)));  // R3
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);                                     // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                               // R4

endmodule

// File: tb/chain_enumerator_test.sv
module chain_enumerator_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        xfer_done = 1'b0;
   logic [31:0] rsp_word = '0;
   logic        cmd_valid, cmd_read, cmd_all, busy, done, err;
   logic [4:0]  cmd_dev;
   logic [5:0]  cmd_reg;
   logic [7:0]  cmd_data;
   logic [3:0]  dev_count;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] resp [10];
   logic [5:0]  wr_reg  [3];
   logic [7:0]  wr_data [3];
   logic        wr_all  [3];
   logic [4:0]  wr_dev  [3];
   int          n_wr, n_rd;
   logic        saw_done, err_first, err_at_done, done_after, busy_after;
   logic [3:0]  cnt_at_done;

   always #4 clk = ~clk;

   chain_enumerator uut (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer_done(xfer_done), .rsp_word(rsp_word),
      .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
      .cmd_all(cmd_all), .cmd_data(cmd_data), .busy(busy), .done(done), .err(err),
      .dev_count(dev_count)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_crc(input logic [21:0] d);
      logic [29:0] acc;
      acc = {8'b0, d};
      for (int k = 21; k >= 8; k--)
         if (acc[k]) acc = acc ^ (30'h12F << (k - 8));
      return acc[7:0];
   endfunction

   function automatic logic [31:0] mk_frame(input int pos, input logic [16:0] payload);
      logic [31:0] w;
      for (int b = 0; b < 5; b++) w[31-b] = pos[b];
      w[26:10] = payload;
      w[9:2]   = ref_crc(w[31:10]);
      w[1:0]   = 2'b00;
      return w;
   endfunction

   task automatic fill_chain(input int ndev);
      for (int i = 0; i < 10; i++) resp[i] = '0;
      for (int i = 0; i < ndev && i < 10; i++) resp[i] = mk_frame(i, 17'(32'h1A5C3 + i * 977));
   endtask

   task automatic run_scan(input int poke_at, input bit poke_done);
      int ncmd;
      ncmd = 0; n_wr = 0; n_rd = 0; saw_done = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      err_first = err;
      for (int it = 0; it < 80 && !saw_done; it++) begin
         if (done) begin
            saw_done = 1'b1;
            cnt_at_done = dev_count;
            err_at_done = err;
            if (poke_done) start = 1'b1;
         end else if (cmd_valid) begin
            if (cmd_read) begin
               rsp_word = (n_rd < 10) ? resp[n_rd] : 32'hFFFF_FFFF;
               n_rd++;
            end else begin
               if (n_wr < 3) begin
                  wr_reg[n_wr] = cmd_reg; wr_data[n_wr] = cmd_data;
                  wr_all[n_wr] = cmd_all; wr_dev[n_wr] = cmd_dev;
               end
               n_wr++;
            end
            if (ncmd == poke_at) start = 1'b1;
            @(negedge clk); start = 1'b0;
            @(negedge clk); xfer_done = 1'b1;
            @(negedge clk); xfer_done = 1'b0; rsp_word = '0;
            ncmd++;
         end else begin
            @(negedge clk);
         end
      end
      if (saw_done) begin
         @(negedge clk); start = 1'b0;
         done_after = done;
         busy_after = busy;
      end
      chk("R4 scan completes", 32'(saw_done), 1);
   endtask

   task automatic t_reset;
      chk("R1 busy", 32'(busy), 0);
      chk("R1 done", 32'(done), 0);
      chk("R1 err", 32'(err), 0);
      chk("R1 cmd_valid", 32'(cmd_valid), 0);
      chk("R1 dev_count", 32'(dev_count), 0);
   endtask

   task automatic t_three_dev;
      fill_chain(3);
      run_scan(-1, 1'b0);
      chk("R2 write count", 32'(n_wr), 3);
      chk("R2 w0 reg", 32'(wr_reg[0]), 32'h0E);
      chk("R2 w0 data", 32'(wr_data[0]), 32'h95);
      chk("R2 w1 reg", 32'(wr_reg[1]), 32'h0E);
      chk("R2 w1 data", 32'(wr_data[1]), 32'h15);
      chk("R2 w2 reg", 32'(wr_reg[2]), 32'h1C);
      chk("R2 w2 data", 32'(wr_data[2]), 32'h38);
      for (int i = 0; i < 3; i++) begin
         chk("R2 broadcast", 32'(wr_all[i]), 1);
         chk("R2 master addr", 32'(wr_dev[i]), 0);
      end
      chk("R3 read count", 32'(n_rd), 4);
      chk("R4 count", 32'(cnt_at_done), 2);
      chk("R4 err", 32'(err_at_done), 0);
      chk("R4 done one cycle", 32'(done_after), 0);
   endtask

   task automatic t_bad_crc;
      fill_chain(3);
      resp[1] = resp[1] ^ 32'h4;
      run_scan(-1, 1'b0);
      chk("R5 reads until bad crc", 32'(n_rd), 2);
      chk("R5 err", 32'(err_at_done), 1);
      chk("R9 count kept", 32'(cnt_at_done), 2);
      chk("R9 err sticky", 32'(err), 1);
   endtask

   task automatic t_bad_pos;
      fill_chain(3);
      resp[1] = mk_frame(2, 17'h0BEEF);
      run_scan(-1, 1'b0);
      chk("R10 err cleared by start", 32'(err_first), 0);
      chk("R6 reads until bad addr", 32'(n_rd), 2);
      chk("R6 err", 32'(err_at_done), 1);
      chk("R9 count kept", 32'(cnt_at_done), 2);
   endtask

   task automatic t_one_dev_and_late_start;
      fill_chain(1);
      run_scan(-1, 1'b1);
      chk("R4 single device count", 32'(cnt_at_done), 0);
      chk("R4 single err", 32'(err_at_done), 0);
      chk("R10 start in done cycle: busy", 32'(busy_after), 0);
      for (int i = 0; i < 4; i++) begin
         chk("R10 start in done cycle: no command", 32'(cmd_valid), 0);
         @(negedge clk);
      end
   endtask

   task automatic t_full_chain;
      fill_chain(8);
      run_scan(-1, 1'b0);
      chk("R4 full chain reads", 32'(n_rd), 9);
      chk("R4 full chain count", 32'(cnt_at_done), 7);
      chk("R4 full chain err", 32'(err_at_done), 0);
   endtask

   task automatic t_overflow;
      fill_chain(9);
      run_scan(-1, 1'b0);
      chk("R7 read cap", 32'(n_rd), 9);
      chk("R7 err", 32'(err_at_done), 1);
      chk("R9 count kept", 32'(cnt_at_done), 7);
   endtask

   task automatic t_empty;
      fill_chain(0);
      run_scan(-1, 1'b0);
      chk("R8 reads", 32'(n_rd), 1);
      chk("R8 err", 32'(err_at_done), 1);
      chk("R8 count kept", 32'(cnt_at_done), 7);
   endtask

   task automatic t_start_while_busy;
      fill_chain(2);
      run_scan(1, 1'b0);
      chk("R10 busy start: writes", 32'(n_wr), 3);
      chk("R10 busy start: reads", 32'(n_rd), 3);
      chk("R10 busy start: count", 32'(cnt_at_done), 1);
      chk("R10 busy start: err", 32'(err_at_done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_three_dev();
      t_bad_crc();
      t_bad_pos();
      t_one_dev_and_late_start();
      t_full_chain();
      t_overflow();
      t_empty();
      t_start_while_busy();
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule